// File: doc/BRIEF.md
# Dual-Direction Message Mailbox

This block lets an application processor and an I/O co-processor pass short messages to each other through two independent hardware queues behind one shared register window. Channel 0 always carries traffic from the application side to the I/O side; channel 1 always carries traffic the other way. Each message is a 64-bit first word plus a 32-bit second word. A sender stages the first word, then writes the second word, and that second write pushes the combined entry. A receiver may peek at the head's first word. Reading the head's second word pops the entry and also returns the queue's occupancy and pointer state in the upper bits.

Four interrupt causes report the empty and not-empty state of each queue. Each cause is sticky: once its condition has been seen, it stays pending until software acknowledges it. While its condition still holds, it stays pending through the acknowledge as well. An enable register gates each cause onto its level-sensitive output line. The bus is a single-cycle port. Read data is combinational in the cycle the read strobe is high, and every write or pop takes effect at the clock edge that ends that cycle.

Top module: `mbx_mailbox_top`

## Requirements
- R1: After reset both queues are empty (control bit 17 = 1, bit 16 = 0, bit 18 = 0), the interrupt enable reads 0, all irq lines are 0, and all pointers and counts are 0.
- R2: A write to send word 0 (0x60 for channel 0, 0x90 for channel 1) only stages the 64-bit first word and leaves occupancy unchanged. A write to send word 1 (0x68 / 0x98) pushes {staged word, wdata[31:0]} as one entry, and wdata[63:32] is ignored.
- R3: Reading receive word 0 (0x70 / 0xA0) returns the head's first word without popping. Reading receive word 1 (0x78 / 0xA8) returns the head's second word in bits 31:0 and pops the entry, so entries leave in the order they were pushed.
- R4: The control register (0x50 / 0x80) reports full in bit 16 once 16 entries are held. A push while full is dropped and sets the sticky overflow bit 18. Writing 1 to control bit 18 clears it.
- R5: A read of receive word 0 or 1 on an empty queue returns 0 in the message bits and neither pops nor moves any pointer.
- R6: A read of receive word 1 also reports the state as it was before that read's pop. Bits 56:52 hold the occupancy, bits 51:48 hold the dropped-push count (saturating at 15, cleared together with bit 18), bits 47:44 hold the read pointer and bits 43:40 hold the write pointer.
- R7: The two queues are independent. Traffic on one channel changes neither the flags nor the contents of the other.
- R8: The cause bits, used identically in the enable (0x48) and acknowledge (0x4C) registers, are: bit 0 = channel 0 empty, bit 1 = channel 0 not empty, bit 2 = channel 1 empty, bit 3 = channel 1 not empty. irq[i] is high exactly when cause i is pending and enable bit i is set.
- R9: A cause whose condition was true at any earlier cycle stays pending after the condition ends, until a 1 is written to its acknowledge bit. If the condition is false at that write, the cause reads 0 from the next cycle.
- R10: If a cause's condition still holds when it is acknowledged, the cause and its enabled irq line remain asserted in the following cycle.
- R11: Reading 0x4C returns the pending causes before enable gating, and reading 0x48 returns the enables. Unmapped addresses read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe; pops when it hits a receive word 1 address |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational while bus_rd is high, else 0 |
| irq | output | 4 | Level interrupt lines, one per cause, bit order as in R8 |

## Verification
Read data is due in the same cycle as the read strobe. The bench drives each access at a falling edge and samples bus_rdata 1 ns later, before the rising edge that performs any pop. Writes, pushes, pops, acknowledges and enable changes are due one rising edge after the strobe. Each task therefore drops its strobe at the next falling edge and observes the effect no earlier than that edge, through register reads or the irq pins. Interrupt checks are made at the falling edge straight after an acknowledge edge. That is where a held condition must already show the line still high and a finished one must show it low.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

   localparam int unsigned N_CH      = 2;            // 0: app -> io, 1: io -> app
   localparam int unsigned N_IRQ     = 2 * N_CH;
   localparam int unsigned W0_W      = 64;
   localparam int unsigned W1_W      = 32;
   localparam int unsigned DATA_W    = 64;
   localparam int unsigned DROP_W    = 4;

   // control register flag positions
   localparam int unsigned FULL_BIT  = 16;
   localparam int unsigned EMPTY_BIT = 17;
   localparam int unsigned OVF_BIT   = 18;

   // status fields returned with receive word 1
   localparam int unsigned ST_CNT_LO  = 52;
   localparam int unsigned ST_CNT_W   = 5;
   localparam int unsigned ST_DROP_LO = 48;
   localparam int unsigned ST_RPTR_LO = 44;
   localparam int unsigned ST_WPTR_LO = 40;
   localparam int unsigned ST_PTR_W   = 4;

   localparam logic [7:0] OFS_IRQ_EN  = 8'h48;
   localparam logic [7:0] OFS_IRQ_ACK = 8'h4C;

   typedef struct packed {
      logic [W0_W-1:0] w0;
      logic [W1_W-1:0] w1;
   } mbx_msg_t;

   function automatic logic [7:0] ofs_ctrl(input int ch);
      return (ch == 0) ? 8'h50 : 8'h80;
   endfunction

   function automatic logic [7:0] ofs_data_base(input int ch);
      return (ch == 0) ? 8'h60 : 8'h90;
   endfunction

   function automatic logic [7:0] ofs_tx0(input int ch);
      return ofs_data_base(ch);
   endfunction

   function automatic logic [7:0] ofs_tx1(input int ch);
      return ofs_data_base(ch) + 8'h08;
   endfunction

   function automatic logic [7:0] ofs_rx0(input int ch);
      return ofs_data_base(ch) + 8'h10;
   endfunction

   function automatic logic [7:0] ofs_rx1(input int ch);
      return ofs_data_base(ch) + 8'h18;
   endfunction

endpackage

// File: rtl/mbx_fifo.sv
`timescale 1ns/1ps
module mbx_fifo
   import mbx_pkg::*;
#(
   parameter int unsigned DEPTH = 16
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push_i,
   input  mbx_msg_t                      push_msg_i,
   input  logic                          pop_i,
   input  logic                          ovf_clr_i,
   output mbx_msg_t                      head_o,
   output logic [$clog2(DEPTH+1)-1:0]    count_o,
   output logic [$clog2(DEPTH)-1:0]      rd_ptr_o,
   output logic [$clog2(DEPTH)-1:0]      wr_ptr_o,
   output logic                          full_o,
   output logic                          empty_o,
   output logic [DROP_W-1:0]             drops_o
);

   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(DEPTH);
   localparam logic [DROP_W-1:0] DROP_MAX = '1;

   generate
      if (DEPTH < 2 || DEPTH > 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mbx_fifo: DEPTH must be a power of two from 2 to 16");
      end
   endgenerate

   mbx_msg_t          mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
   logic [CNT_W-1:0]  count_q;
   logic [DROP_W-1:0] drops_q;
   logic              do_push, do_pop;

   assign full_o  = (count_q == CNT_MAX);
   assign empty_o = (count_q == '0);
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         unique case ({do_push, do_pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drops_q <= '0;
      end else if (ovf_clr_i) begin
         drops_q <= '0;
      end else if (push_i && full_o && drops_q != DROP_MAX) begin
         drops_q <= drops_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr_q] <= push_msg_i;
   end

   assign head_o   = mem[rd_ptr_q];
   assign count_o  = count_q;
   assign rd_ptr_o = rd_ptr_q;
   assign wr_ptr_o = wr_ptr_q;
   assign drops_o  = drops_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CNT_MAX);                                                     // R4
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o && !pop_i) |=> ($stable(count_o) && $stable(wr_ptr_o))); // R4
   AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !full_o && !pop_i) |=> (count_o == $past(count_o) + 1'b1));   // R2
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o && !push_i) |=> ($stable(rd_ptr_o) && count_o == '0)); // R5
   AST_DROP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_clr_i |=> (drops_o >= $past(drops_o)));                             // R6

endmodule

// File: rtl/mbx_irq.sv
`timescale 1ns/1ps
module mbx_irq #(
   parameter int unsigned N      = 4,
   parameter bit          STICKY = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] ack_i,
   output logic [N-1:0] pending_o,
   output logic [N-1:0] irq_o
);

   generate
      if (N == 0) begin : g_bad_n
         $error("mbx_irq: N must be at least 1");
      end

      if (STICKY) begin : g_sticky
         logic [N-1:0] seen_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seen_q <= '0;
            else        seen_q <= (seen_q | cond_i) & ~ack_i;
         end

         assign pending_o = seen_q | cond_i;

         AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((($past(cond_i) & ~$past(ack_i)) & ~pending_o) == '0)); // R9
         AST_ACK_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((pending_o & ~cond_i) & $past(ack_i)) == '0));          // R9
      end else begin : g_level
         logic unused_ack;
         assign unused_ack = ^ack_i;
         assign pending_o  = cond_i;
      end
   endgenerate

   assign irq_o = pending_o & en_i;

endmodule

// File: rtl/mbx_regs.sv
`timescale 1ns/1ps
module mbx_regs
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned PTR_W  = 4
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rd_i,
   input  logic                               wr_i,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic [DATA_W-1:0]                  wdata_i,
   output logic [DATA_W-1:0]                  rdata_o,
   input  mbx_msg_t [N_CH-1:0]                head_i,
   input  logic [N_CH-1:0][CNT_W-1:0]         cnt_i,
   input  logic [N_CH-1:0][PTR_W-1:0]         rptr_i,
   input  logic [N_CH-1:0][PTR_W-1:0]         wptr_i,
   input  logic [N_CH-1:0]                    full_i,
   input  logic [N_CH-1:0]                    empty_i,
   input  logic [N_CH-1:0][DROP_W-1:0]        drops_i,
   input  logic [N_IRQ-1:0]                   pending_i,
   output logic [N_CH-1:0]                    push_o,
   output mbx_msg_t [N_CH-1:0]                push_msg_o,
   output logic [N_CH-1:0]                    pop_o,
   output logic [N_CH-1:0]                    ovf_clr_o,
   output logic [N_IRQ-1:0]                   irq_en_o,
   output logic [N_IRQ-1:0]                   irq_ack_o
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("mbx_regs: ADDR_W must be at least 8");
      end
      if (CNT_W > ST_CNT_W || PTR_W > ST_PTR_W) begin : g_bad_fields
         $error("mbx_regs: queue state does not fit the status fields");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_IRQ_EN);
   localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(OFS_IRQ_ACK);

   logic [N_CH-1:0][W0_W-1:0] stage_q;
   logic [N_IRQ-1:0]          irq_en_q;
   logic [DATA_W-1:0]         mux;

   genvar ch;
   generate
      for (ch = 0; ch < N_CH; ch++) begin : g_ch
         localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ofs_ctrl(ch));
         localparam logic [ADDR_W-1:0] A_TX0  = ADDR_W'(ofs_tx0(ch));
         localparam logic [ADDR_W-1:0] A_TX1  = ADDR_W'(ofs_tx1(ch));
         localparam logic [ADDR_W-1:0] A_RX1  = ADDR_W'(ofs_rx1(ch));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          stage_q[ch] <= '0;
            else if (wr_i && addr_i == A_TX0)    stage_q[ch] <= wdata_i;
         end

         assign push_o[ch]     = wr_i && (addr_i == A_TX1);
         assign push_msg_o[ch] = {stage_q[ch], wdata_i[W1_W-1:0]};
         assign pop_o[ch]      = rd_i && (addr_i == A_RX1);
         assign ovf_clr_o[ch]  = wr_i && (addr_i == A_CTRL) && wdata_i[OVF_BIT];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         irq_en_q <= '0;
      else if (wr_i && addr_i == A_EN)    irq_en_q <= wdata_i[N_IRQ-1:0];
   end

   assign irq_en_o  = irq_en_q;
   assign irq_ack_o = (wr_i && addr_i == A_ACK) ? wdata_i[N_IRQ-1:0] : '0;

   always_comb begin
      mux = '0;
      if (addr_i == A_EN)  mux[N_IRQ-1:0] = irq_en_q;
      if (addr_i == A_ACK) mux[N_IRQ-1:0] = pending_i;
      for (int c = 0; c < N_CH; c++) begin
         if (addr_i == ADDR_W'(ofs_ctrl(c))) begin
            mux[FULL_BIT]  = full_i[c];
            mux[EMPTY_BIT] = empty_i[c];
            mux[OVF_BIT]   = |drops_i[c];
         end
         if (addr_i == ADDR_W'(ofs_rx0(c))) begin
            mux = empty_i[c] ? '0 : head_i[c].w0;
         end
         if (addr_i == ADDR_W'(ofs_rx1(c))) begin
            mux[ST_CNT_LO  +: ST_CNT_W] = ST_CNT_W'(cnt_i[c]);
            mux[ST_DROP_LO +: DROP_W]   = drops_i[c];
            mux[ST_RPTR_LO +: ST_PTR_W] = ST_PTR_W'(rptr_i[c]);
            mux[ST_WPTR_LO +: ST_PTR_W] = ST_PTR_W'(wptr_i[c]);
            mux[W1_W-1:0]               = empty_i[c] ? '0 : head_i[c].w1;
         end
      end
      rdata_o = rd_i ? mux : '0;
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_o, pop_o}));                                               // R7

endmodule

// File: rtl/mbx_mailbox_top.sv
`timescale 1ns/1ps
module mbx_mailbox_top
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DEPTH      = 16,
   parameter bit          STICKY_IRQ = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [63:0]        bus_wdata,
   output logic [63:0]        bus_rdata,
   output logic [3:0]         irq
);

   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   mbx_msg_t [N_CH-1:0]         head;
   mbx_msg_t [N_CH-1:0]         push_msg;
   logic [N_CH-1:0][CNT_W-1:0]  cnt;
   logic [N_CH-1:0][PTR_W-1:0]  rptr, wptr;
   logic [N_CH-1:0][DROP_W-1:0] drops;
   logic [N_CH-1:0]             full, empty, push, pop, ovf_clr;
   logic [N_IRQ-1:0]            cond, irq_en, irq_ack, pending;

   genvar ch;
   generate
      for (ch = 0; ch < N_CH; ch++) begin : g_q
         mbx_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (push[ch]),
            .push_msg_i (push_msg[ch]),
            .pop_i      (pop[ch]),
            .ovf_clr_i  (ovf_clr[ch]),
            .head_o     (head[ch]),
            .count_o    (cnt[ch]),
            .rd_ptr_o   (rptr[ch]),
            .wr_ptr_o   (wptr[ch]),
            .full_o     (full[ch]),
            .empty_o    (empty[ch]),
            .drops_o    (drops[ch])
         );
         assign cond[2*ch]     = empty[ch];
         assign cond[2*ch + 1] = ~empty[ch];
      end
   endgenerate

   mbx_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_i       (bus_rd),
      .wr_i       (bus_wr),
      .addr_i     (bus_addr),
      .wdata_i    (bus_wdata),
      .rdata_o    (bus_rdata),
      .head_i     (head),
      .cnt_i      (cnt),
      .rptr_i     (rptr),
      .wptr_i     (wptr),
      .full_i     (full),
      .empty_i    (empty),
      .drops_i    (drops),
      .pending_i  (pending),
      .push_o     (push),
      .push_msg_o (push_msg),
      .pop_o      (pop),
      .ovf_clr_o  (ovf_clr),
      .irq_en_o   (irq_en),
      .irq_ack_o  (irq_ack)
   );

   mbx_irq #(.N(N_IRQ), .STICKY(STICKY_IRQ)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cond_i    (cond),
      .en_i      (irq_en),
      .ack_i     (irq_ack),
      .pending_o (pending),
      .irq_o     (irq)
   );

   AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == ADDR_W'(ofs_rx0(0))) |=> $stable(cnt[0])); // R3
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_IRQ_EN) && bus_wdata[3:0] == 4'h0) |=> (irq == 4'h0)); // R8
   AST_CH_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(ofs_tx1(0))) |=> $stable(cnt[1]));        // R7

endmodule

// File: tb/test_mbx_mailbox_top.sv
`timescale 1ns/1ps
module test_mbx_mailbox_top;

   localparam real CLK_HALF = 2.5;   // 200 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic [3:0]  irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   mbx_mailbox_top i_mbx_mailbox_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   localparam logic [63:0] F_FULL  = 64'h1 << 16;
   localparam logic [63:0] F_EMPTY = 64'h1 << 17;
   localparam logic [63:0] F_OVF   = 64'h1 << 18;

   function automatic logic [63:0] stat(input int cnt, input int drp, input int rp,
                                        input int wp, input logic [31:0] w1);
      return (64'(cnt) << 52) | (64'(drp) << 48) | (64'(rp) << 44) | (64'(wp) << 40) | 64'(w1);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic send(input logic [7:0] base, input logic [63:0] w0, input logic [63:0] w1);
      wr(base, w0);
      wr(base + 8'h08, w1);
   endtask

   task automatic t_reset();
      logic [63:0] d;
      check("R1", "irq after reset", 64'(irq), 64'h0);
      rd(8'h50, d); check("R1", "ch0 control", d, F_EMPTY);
      rd(8'h80, d); check("R1", "ch1 control", d, F_EMPTY);
      rd(8'h48, d); check("R1", "enable", d, 64'h0);
      rd(8'h78, d); check("R5", "ch0 empty rx1", d, 64'h0);
      rd(8'h70, d); check("R5", "ch0 empty rx0", d, 64'h0);
   endtask

   task automatic t_send_recv();
      logic [63:0] d;
      wr(8'h60, 64'hA1A2_A3A4_A5A6_A7A8);
      rd(8'h50, d); check("R2", "stage only", d, F_EMPTY);
      wr(8'h68, 64'hFFFF_FFFF_1234_5678);
      rd(8'h50, d); check("R2", "after push", d, 64'h0);
      send(8'h60, 64'hB1B2_B3B4_B5B6_B7B8, 64'h0000_0000_0000_0B0B);
      rd(8'h70, d); check("R3", "peek head", d, 64'hA1A2_A3A4_A5A6_A7A8);
      rd(8'h70, d); check("R3", "peek again", d, 64'hA1A2_A3A4_A5A6_A7A8);
      rd(8'h78, d); check("R6", "pop first", d, stat(2, 0, 0, 2, 32'h1234_5678));
      rd(8'h70, d); check("R3", "second head", d, 64'hB1B2_B3B4_B5B6_B7B8);
      rd(8'h78, d); check("R6", "pop second", d, stat(1, 0, 1, 2, 32'h0000_0B0B));
      rd(8'h78, d); check("R5", "empty pop", d, stat(0, 0, 2, 2, 32'h0));
      rd(8'h78, d); check("R5", "pointers held", d, stat(0, 0, 2, 2, 32'h0));
   endtask

   task automatic t_full_overflow();
      logic [63:0] d;
      for (int i = 0; i < 16; i++) send(8'h60, 64'(i), 64'(100 + i));
      rd(8'h50, d); check("R4", "full flag", d, F_FULL);
      send(8'h60, 64'hDEAD, 64'hBEEF);
      rd(8'h50, d); check("R4", "overflow flag", d, F_FULL | F_OVF);
      rd(8'h78, d); check("R6", "status full", d, stat(16, 1, 2, 2, 32'd100));
      for (int i = 1; i < 16; i++) begin
         rd(8'h70, d); check("R3", "order w0", d, 64'(i));
         rd(8'h78, d); check("R3", "order w1", 64'(d[31:0]), 64'(100 + i));
      end
      rd(8'h50, d); check("R4", "overflow sticky", d, F_EMPTY | F_OVF);
      wr(8'h50, F_OVF);
      rd(8'h50, d); check("R4", "overflow cleared", d, F_EMPTY);
   endtask

   task automatic t_drop_saturate();
      logic [63:0] d;
      for (int i = 0; i < 16; i++) send(8'h60, 64'(i), 64'(i));
      for (int i = 0; i < 20; i++) wr(8'h68, 64'h77);
      rd(8'h78, d); check("R6", "drops saturate", d, stat(16, 15, 2, 2, 32'd0));
      for (int i = 1; i < 16; i++) rd(8'h78, d);
      wr(8'h50, F_OVF);
      rd(8'h78, d); check("R6", "drops cleared", d, stat(0, 0, 2, 2, 32'h0));
   endtask

   task automatic t_reverse();
      logic [63:0] d;
      send(8'h90, 64'hC0C0_C0C0_1111_2222, 64'h0000_CAFE);
      rd(8'h80, d); check("R7", "ch1 not empty", d, 64'h0);
      rd(8'h50, d); check("R7", "ch0 untouched", d, F_EMPTY);
      rd(8'h70, d); check("R7", "ch0 no data", d, 64'h0);
      rd(8'hA0, d); check("R3", "ch1 peek", d, 64'hC0C0_C0C0_1111_2222);
      rd(8'hA8, d); check("R6", "ch1 pop", d, stat(1, 0, 0, 1, 32'h0000_CAFE));
      rd(8'h80, d); check("R7", "ch1 empty again", d, F_EMPTY);
   endtask

   task automatic t_irq();
      logic [63:0] d;
      rd(8'h4C, d); check("R9", "past causes pending", d, 64'hF);
      check("R8", "masked lines", 64'(irq), 64'h0);
      wr(8'h4C, 64'hF);
      rd(8'h4C, d); check("R10", "held causes survive ack", d, 64'h5);
      wr(8'h48, 64'hF);
      check("R8", "enabled lines", 64'(irq), 64'h5);
      send(8'h60, 64'h1, 64'h2);
      check("R8", "ch0 not empty line", 64'(irq), 64'h7);
      wr(8'h4C, 64'h1);
      check("R9", "ack of past empty", 64'(irq), 64'h6);
      rd(8'h78, d);
      check("R9", "not empty sticky", 64'(irq), 64'h7);
      wr(8'h4C, 64'h2);
      check("R9", "ack not empty", 64'(irq), 64'h5);
      wr(8'h4C, 64'h1);
      check("R10", "line held through ack", 64'(irq), 64'h5);
      wr(8'h48, 64'h2);
      check("R8", "enable gates lines", 64'(irq), 64'h0);
      rd(8'h48, d); check("R11", "enable readback", d, 64'h2);
   endtask

   task automatic t_unmapped();
      logic [63:0] d;
      rd(8'h58, d); check("R11", "unmapped read", d, 64'h0);
      wr(8'hF0, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(8'h40, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(8'h48, d); check("R11", "enable after stray write", d, 64'h2);
      rd(8'h50, d); check("R11", "ch0 after stray write", d, F_EMPTY);
      rd(8'h80, d); check("R11", "ch1 after stray write", d, F_EMPTY);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_send_recv();
      t_full_overflow();
      t_drop_saturate();
      t_reverse();
      t_irq();
      t_unmapped();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule